// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a processor-side request port and a downstream memory port. Two 32 MB alias windows are mapped so that every 32-bit-aligned alias word stands for one bit of real memory. An access that lands in a window is turned into a single-bit access on the real byte, halfword or word. A read returns 0 or 1. A write becomes a locked read-modify-write that sets or clears only the chosen bit.

All other addresses pass through with nothing altered. The upstream side takes one request at a time. `reqReady` stays low until the single `rspValid` pulse for that request. Data is right-justified on both ports, and memory is little-endian. Sizes are encoded as 0 = byte, 1 = halfword, 2 = word. Code 3 is handled as word.

Top module: `bitband_bridge`

## Requirements
- R1: An address is an alias access when bits [31:25] match the window at 0x2200_0000 or the window at 0x4200_0000. Addresses 0x21FF_FFFC and 0x2400_0000 are not alias accesses.
- R2: For an alias access, the downstream address is alias bits [31:29] kept in place, OR-ed with alias bits [24:0] shifted right by 5.
- R3: The selected bit number is alias bits [6:2], taken modulo 8 for size 0, modulo 16 for size 1 and modulo 32 for size 2. Data is right-justified and little-endian, so bit n is bit n mod 8 of byte n div 8.
- R4: For size 1 the downstream address has bit 0 cleared. For size 2 it has bits [1:0] cleared.
- R5: An alias read returns 1 in bit 0 when the selected memory bit is set and 0 when it is clear. Bits [31:1] are zero.
- R6: An alias write reads the real location, sets the selected bit if write-data bit 0 is 1 and clears it otherwise, and writes the result back. Every other bit of that location, and all upper write-data bits, have no effect.
- R7: The read and write-back of an alias write are issued with `memLock` high from the read request until the write-back is accepted. No other downstream transfer comes between them. A pending downstream request holds its address and direction until accepted.
- R8: A non-alias request is forwarded with address, size, write data and direction unchanged, and its read data is returned unchanged.
- R9: Each accepted request produces exactly one `rspValid` pulse. `reqReady` is low from acceptance until that pulse. Write responses carry zero data.
- R10: After reset, `reqReady` is high and `memValid`, `memLock` and `rspValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Upstream request present |
| reqReady | output | 1 | Bridge can accept a request |
| reqAddr | input | 32 | Request byte address |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqWrite | input | 1 | 1 = write |
| reqWdata | input | 32 | Right-justified write data |
| rspValid | output | 1 | One-cycle response pulse |
| rspRdata | output | 32 | Response data (zero for writes) |
| memValid | output | 1 | Downstream request present |
| memReady | input | 1 | Downstream accepts request |
| memAddr | output | 32 | Downstream byte address |
| memSize | output | 2 | Downstream access size |
| memWrite | output | 1 | Downstream direction |
| memWdata | output | 32 | Downstream write data |
| memLock | output | 1 | Held across a read-modify-write |
| memRspValid | input | 1 | Downstream read data valid |
| memRdata | input | 32 | Downstream read data |

## Verification
Alias reads sweep every bit of a byte that holds a mixed pattern, so a wrong bit index or a wrong polarity shows up as a mismatch on a single bit. A halfword alias built from an odd real byte, and word aliases at bits 17, 26 and 31, separate modulo width, forced alignment and little-endian lane order. Alias writes use data whose upper bits differ from bit 0, in both windows, and the bench compares the surrounding memory bytes to prove that only one bit moves. Pass-through traffic and the addresses just outside a window show whether the window decode is too wide or the forwarding path alters anything. Random downstream stalls test that requests stay held and that the lock holds across the read and write-back.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic capture;    // latch the upstream request
    logic captureRd;  // latch downstream read data
    logic writeBack;  // drive the modified word downstream
  } dpStrobe_t;
endpackage

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          WIN_BITS  = 25,
  parameter int          KEEP_BITS = 3,
  parameter logic [31:0] WIN0_BASE = 32'h2200_0000,
  parameter logic [31:0] WIN1_BASE = 32'h4200_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memValid,
  output logic              isAliasIn,
  output logic              aliasQ,
  output logic              writeQ,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspRdata
);
  localparam int BIT_W     = $clog2(DATA_W);
  localparam int SEL_LSB   = 2;                       // one alias word per bit
  localparam int ADDR_SHR  = SEL_LSB + 3;             // 8 bits per byte
  localparam int HI_W      = ADDR_W - WIN_BITS;
  localparam int LOW_W     = ADDR_W - KEEP_BITS;

  logic [ADDR_W-1:0] reqAddrQ;
  logic [1:0]        sizeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdDataQ;

  // window decode on the live request
  always_comb begin
    isAliasIn = (reqAddr[ADDR_W-1:WIN_BITS] == WIN0_BASE[ADDR_W-1:WIN_BITS]) ||
                (reqAddr[ADDR_W-1:WIN_BITS] == WIN1_BASE[ADDR_W-1:WIN_BITS]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddrQ <= '0;
      sizeQ    <= '0;
      wdataQ   <= '0;
      writeQ   <= 1'b0;
      aliasQ   <= 1'b0;
      rdDataQ  <= '0;
    end else begin
      if (strb.capture) begin
        reqAddrQ <= reqAddr;
        sizeQ    <= reqSize;
        wdataQ   <= reqWdata;
        writeQ   <= reqWrite;
        aliasQ   <= isAliasIn;
      end
      if (strb.captureRd) begin
        rdDataQ <= memRdata;
      end
    end
  end

  // real address: keep the top bits, fold in the window offset
  logic [ADDR_W-1:0] realRaw;
  logic [ADDR_W-1:0] realAligned;
  logic [ADDR_W-1:0] offsetBits;

  always_comb begin
    offsetBits  = {{HI_W{1'b0}}, reqAddrQ[WIN_BITS-1:0]} >> ADDR_SHR;
    realRaw     = {reqAddrQ[ADDR_W-1:LOW_W], {LOW_W{1'b0}}} | offsetBits;
    realAligned = realRaw;
    case (sizeQ)
      SZ_BYTE: realAligned = realRaw;
      SZ_HALF: realAligned = {realRaw[ADDR_W-1:1], 1'b0};
      default: realAligned = {realRaw[ADDR_W-1:2], 2'b00};
    endcase
  end

  // bit select and lane masks per access size
  logic [BIT_W-1:0]  bitNum;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] sizeMask;

  always_comb begin
    case (sizeQ)
      SZ_BYTE: begin
        bitNum   = BIT_W'(reqAddrQ[SEL_LSB+2:SEL_LSB]);
        sizeMask = DATA_W'({8{1'b1}});
      end
      SZ_HALF: begin
        bitNum   = BIT_W'(reqAddrQ[SEL_LSB+3:SEL_LSB]);
        sizeMask = DATA_W'({16{1'b1}});
      end
      default: begin
        bitNum   = reqAddrQ[SEL_LSB+BIT_W-1:SEL_LSB];
        sizeMask = '1;
      end
    endcase
    bitMask = DATA_W'(1) << bitNum;
  end

  logic [DATA_W-1:0] modified;
  always_comb begin
    if (wdataQ[0]) modified = (rdDataQ | bitMask) & sizeMask;
    else           modified = (rdDataQ & ~bitMask) & sizeMask;
  end

  always_comb begin
    memAddr  = aliasQ ? realAligned : reqAddrQ;
    memSize  = sizeQ;
    memWdata = strb.writeBack ? modified : wdataQ;
    if (writeQ)      rspRdata = '0;
    else if (aliasQ) rspRdata = {{(DATA_W-1){1'b0}}, |(rdDataQ & bitMask)};
    else             rspRdata = rdDataQ;
  end

  // write-back carries wdata bit 0 in the selected position (R6)
  p_wb_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && strb.writeBack) |-> (memWdata[bitNum] == wdataQ[0]));

  // write-back leaves every other bit of the read value alone (R6)
  p_wb_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && strb.writeBack) |-> (((memWdata ^ rdDataQ) & sizeMask & ~bitMask) == '0));
endmodule

// File: rtl/bb_control.sv
module bb_control
  import bb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      isAliasIn,
  input  logic      aliasQ,
  input  logic      writeQ,
  input  logic      memReady,
  input  logic      memRspValid,
  output logic      reqReady,
  output logic      rspValid,
  output logic      memValid,
  output logic      memWrite,
  output logic      memLock,
  output dpStrobe_t strb
);
  typedef enum logic [2:0] {
    S_IDLE, S_PASS_REQ, S_PASS_WAIT, S_RD_REQ, S_RD_WAIT, S_WB_REQ, S_RSP
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:      if (reqValid) stateNext = isAliasIn ? S_RD_REQ : S_PASS_REQ;
      S_PASS_REQ:  if (memReady) stateNext = writeQ ? S_RSP : S_PASS_WAIT;
      S_PASS_WAIT: if (memRspValid) stateNext = S_RSP;
      S_RD_REQ:    if (memReady) stateNext = S_RD_WAIT;
      S_RD_WAIT:   if (memRspValid) stateNext = writeQ ? S_WB_REQ : S_RSP;
      S_WB_REQ:    if (memReady) stateNext = S_RSP;
      S_RSP:       stateNext = S_IDLE;
      default:     stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    reqReady       = (state == S_IDLE);
    rspValid       = (state == S_RSP);
    memValid       = (state == S_PASS_REQ) || (state == S_RD_REQ) || (state == S_WB_REQ);
    memWrite       = (state == S_WB_REQ) || ((state == S_PASS_REQ) && writeQ);
    memLock        = aliasQ && writeQ &&
                     ((state == S_RD_REQ) || (state == S_RD_WAIT) || (state == S_WB_REQ));
    strb.capture   = (state == S_IDLE) && reqValid;
    strb.captureRd = ((state == S_PASS_WAIT) || (state == S_RD_WAIT)) && memRspValid;
    strb.writeBack = (state == S_WB_REQ);
  end

  // read data of a locked sequence is followed at once by the write-back (R7)
  p_lock_wb_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RD_WAIT && memRspValid && writeQ) |=> (memValid && memWrite && memLock));

  // a response is a single pulse and reopens the request port (R9)
  p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          WIN_BITS  = 25,
  parameter int          KEEP_BITS = 3,
  parameter logic [31:0] WIN0_BASE = 32'h2200_0000,
  parameter logic [31:0] WIN1_BASE = 32'h4200_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  output logic              memLock,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRdata
);
  dpStrobe_t strb;
  logic      isAliasIn;
  logic      aliasQ;
  logic      writeQ;

  bb_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .isAliasIn  (isAliasIn),
    .aliasQ     (aliasQ),
    .writeQ     (writeQ),
    .memReady   (memReady),
    .memRspValid(memRspValid),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .memValid   (memValid),
    .memWrite   (memWrite),
    .memLock    (memLock),
    .strb       (strb)
  );

  bb_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WIN_BITS (WIN_BITS),
    .KEEP_BITS(KEEP_BITS),
    .WIN0_BASE(WIN0_BASE),
    .WIN1_BASE(WIN1_BASE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .memRdata (memRdata),
    .memValid (memValid),
    .isAliasIn(isAliasIn),
    .aliasQ   (aliasQ),
    .writeQ   (writeQ),
    .memAddr  (memAddr),
    .memSize  (memSize),
    .memWdata (memWdata),
    .rspRdata (rspRdata)
  );

  // a stalled downstream request holds still (R7)
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)));

  // the lock drops only after an accepted write-back (R7)
  p_lock_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memLock) |-> $past(memValid && memReady && memWrite));

  // alias reads answer with a single bit (R5)
  p_alias_rd_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && aliasQ && !writeQ) |-> (rspRdata[DATA_W-1:1] == '0));
endmodule

// File: tb/tb_bitband_bridge.sv
`timescale 1ns/1ps
module tb_bitband_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic        memValid;
  logic        memReady = 1'b0;
  logic [31:0] memAddr;
  logic [1:0]  memSize;
  logic        memWrite;
  logic [31:0] memWdata;
  logic        memLock;
  logic        memRspValid;
  logic [31:0] memRdata;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bitband_bridge dut (.*);

  // ---------------- memory model ----------------
  logic [7:0]  mem [0:4095];
  logic [31:0] lastAddr;
  logic [1:0]  lastSize;
  logic        lastWrite;
  logic [31:0] lastWdata;
  int          lockStep = 0;
  int          lockPairs = 0;
  int          lockBreaks = 0;
  logic [31:0] lockAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 8'h00;
      memRspValid <= 1'b0;
      memRdata    <= '0;
      lockStep    <= 0;
    end else begin
      memRspValid <= 1'b0;
      if (memValid && memReady) begin
        lastAddr  <= memAddr;
        lastSize  <= memSize;
        lastWrite <= memWrite;
        lastWdata <= memWdata;
        if (memWrite) begin
          mem[memAddr[11:0]] <= memWdata[7:0];
          if (memSize != 2'd0) mem[memAddr[11:0] + 12'd1] <= memWdata[15:8];
          if (memSize[1]) begin
            mem[memAddr[11:0] + 12'd2] <= memWdata[23:16];
            mem[memAddr[11:0] + 12'd3] <= memWdata[31:24];
          end
        end else begin
          memRspValid <= 1'b1;
          case (memSize)
            2'd0:    memRdata <= {24'h0, mem[memAddr[11:0]]};
            2'd1:    memRdata <= {16'h0, mem[memAddr[11:0] + 12'd1], mem[memAddr[11:0]]};
            default: memRdata <= {mem[memAddr[11:0] + 12'd3], mem[memAddr[11:0] + 12'd2],
                                  mem[memAddr[11:0] + 12'd1], mem[memAddr[11:0]]};
          endcase
        end
      end
      // lock monitor: locked traffic must be read then write to one address
      if (memLock) begin
        if (memValid && memReady) begin
          if (lockStep == 0 && !memWrite) begin
            lockAddr <= memAddr;
            lockStep <= 1;
          end else if (lockStep == 1 && memWrite && memAddr == lockAddr) begin
            lockStep  <= 2;
            lockPairs <= lockPairs + 1;
          end else begin
            lockBreaks <= lockBreaks + 1;
          end
        end
      end else begin
        if (lockStep == 1) lockBreaks <= lockBreaks + 1;
        if (memValid && memReady && lockStep == 1) lockBreaks <= lockBreaks + 1;
        lockStep <= 0;
      end
    end
  end

  // downstream stalls from an LFSR
  logic [7:0] lfsr = 8'hA7;
  always @(negedge clk) begin
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    memReady <= lfsr[0] | lfsr[2];
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int busyErrs = 0;
  int rspCountErrs = 0;

  task automatic doAccess(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                          input logic [31:0] wd, output logic [31:0] rd);
    int rsps = 0;
    int guard = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0; reqWdata = 32'hDEAD_BEEF; reqAddr = 32'h0BAD_0000;
    rd = 'x;
    while (rsps == 0 && guard < 200) begin
      if (rspValid) begin
        rsps++;
        rd = rspRdata;
      end else if (reqReady) begin
        busyErrs++;
      end
      guard++;
      @(negedge clk);
    end
    if (rspValid) rsps++;
    if (rsps != 1) rspCountErrs++;
  endtask

  function automatic logic [31:0] aliasOf(input logic [31:0] winBase, input int off, input int bitn);
    return winBase + 32'(off) * 32 + 32'(bitn) * 4;
  endfunction

  localparam logic [31:0] W0 = 32'h2200_0000;
  localparam logic [31:0] W1 = 32'h4200_0000;
  localparam logic [31:0] R0 = 32'h2000_0000;
  localparam logic [31:0] R1B = 32'h4000_0000;

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(reqReady === 1'b1, "R10 reqReady", {31'b0, reqReady}, 32'd1);
    check(memValid === 1'b0 && memLock === 1'b0, "R10 memValid/memLock",
          {30'b0, memValid, memLock}, 32'd0);
    check(rspValid === 1'b0, "R10 rspValid", {31'b0, rspValid}, 32'd0);
  endtask

  task automatic t_pass();
    logic [31:0] rd;
    doAccess(32'h1000_0100, 2'd2, 1'b1, 32'hA5A5_1234, rd);
    check(lastAddr == 32'h1000_0100 && lastWrite && lastSize == 2'd2, "R8 pass write addr", lastAddr, 32'h1000_0100);
    check(lastWdata == 32'hA5A5_1234, "R8 pass write data", lastWdata, 32'hA5A5_1234);
    check(rd == 32'h0, "R9 write rsp zero", rd, 32'h0);
    doAccess(32'h1000_0100, 2'd2, 1'b0, 32'h0, rd);
    check(rd == 32'hA5A5_1234, "R8 pass read data", rd, 32'hA5A5_1234);
    doAccess(32'h1000_0102, 2'd0, 1'b0, 32'h0, rd);
    check(rd == 32'h0000_00A5 && lastAddr == 32'h1000_0102 && lastSize == 2'd0,
          "R8 pass byte read", rd, 32'hA5);
  endtask

  task automatic t_alias_byte();
    logic [31:0] rd;
    doAccess(R0 + 32'h10, 2'd0, 1'b1, 32'h0000_005A, rd);
    for (int b = 0; b < 8; b++) begin
      doAccess(aliasOf(W0, 16'h10, b), 2'd0, 1'b0, 32'h0, rd);
      check(rd == ((32'h5A >> b) & 32'h1), "R5 R3 byte bit read", rd, (32'h5A >> b) & 32'h1);
    end
    check(lastAddr == R0 + 32'h10, "R2 byte real address", lastAddr, R0 + 32'h10);
    // clear bit 1: upper data bits set, bit 0 clear
    doAccess(aliasOf(W0, 16'h10, 1), 2'd0, 1'b1, 32'hFFFF_FFFE, rd);
    check(mem[12'h010] == 8'h58, "R6 byte clear", {24'h0, mem[12'h010]}, 32'h58);
    check(rd == 32'h0, "R9 alias write rsp zero", rd, 32'h0);
    doAccess(aliasOf(W0, 16'h10, 0), 2'd0, 1'b1, 32'h0000_0001, rd);
    check(mem[12'h010] == 8'h59, "R6 byte set", {24'h0, mem[12'h010]}, 32'h59);
    check(mem[12'h011] == 8'h00 && mem[12'h00F] == 8'h00, "R6 neighbours untouched",
          {16'h0, mem[12'h011], mem[12'h00F]}, 32'h0);
    check(lockPairs == 2 && lockBreaks == 0, "R7 locked pairs", 32'(lockPairs), 32'd2);
  endtask

  task automatic t_alias_half();
    logic [31:0] rd;
    doAccess(R0 + 32'h20, 2'd1, 1'b1, 32'h0000_8001, rd);
    doAccess(aliasOf(W0, 16'h20, 15), 2'd1, 1'b0, 32'h0, rd);
    check(rd == 32'h1, "R3 half bit15", rd, 32'h1);
    check(lastAddr == R0 + 32'h20 && lastSize == 2'd1, "R4 half aligned", lastAddr, R0 + 32'h20);
    doAccess(aliasOf(W0, 16'h20, 9), 2'd1, 1'b0, 32'h0, rd);
    check(rd == 32'h0, "R5 half bit9 clear", rd, 32'h0);
    doAccess(aliasOf(W0, 16'h20, 9), 2'd1, 1'b1, 32'h0000_0003, rd);
    check(mem[12'h020] == 8'h01 && mem[12'h021] == 8'h82, "R6 R3 half set bit9",
          {16'h0, mem[12'h021], mem[12'h020]}, 32'h8201);
  endtask

  task automatic t_alias_word();
    logic [31:0] rd;
    doAccess(R0 + 32'h40, 2'd2, 1'b1, 32'h8000_0000, rd);
    doAccess(aliasOf(W0, 16'h40, 31), 2'd2, 1'b0, 32'h0, rd);
    check(rd == 32'h1, "R3 word bit31", rd, 32'h1);
    check(lastAddr == R0 + 32'h40, "R4 word aligned", lastAddr, R0 + 32'h40);
    doAccess(aliasOf(W0, 16'h40, 26), 2'd2, 1'b0, 32'h0, rd);
    check(rd == 32'h0 && lastAddr == R0 + 32'h40, "R4 word bit26 aligned", lastAddr, R0 + 32'h40);
    doAccess(aliasOf(W0, 16'h40, 31), 2'd2, 1'b1, 32'h0, rd);
    doAccess(aliasOf(W0, 16'h40, 17), 2'd2, 1'b1, 32'h1, rd);
    check({mem[12'h043], mem[12'h042], mem[12'h041], mem[12'h040]} == 32'h0002_0000,
          "R6 word clear31 set17",
          {mem[12'h043], mem[12'h042], mem[12'h041], mem[12'h040]}, 32'h0002_0000);
  endtask

  task automatic t_window1();
    logic [31:0] rd;
    doAccess(aliasOf(W1, 16'h80, 3), 2'd0, 1'b1, 32'h1, rd);
    check(lastAddr == R1B + 32'h80 && lastWrite, "R1 R2 second window address", lastAddr, R1B + 32'h80);
    check(mem[12'h080] == 8'h08, "R6 second window write", {24'h0, mem[12'h080]}, 32'h08);
    doAccess(aliasOf(W1, 16'h80, 3), 2'd0, 1'b0, 32'h0, rd);
    check(rd == 32'h1, "R5 second window read", rd, 32'h1);
  endtask

  task automatic t_bounds();
    logic [31:0] rd;
    doAccess(32'h2400_0000, 2'd0, 1'b0, 32'h0, rd);
    check(lastAddr == 32'h2400_0000 && rd == 32'h0, "R1 above window passes", lastAddr, 32'h2400_0000);
    doAccess(32'h21FF_FFFC, 2'd2, 1'b1, 32'h1234_5678, rd);
    check(lastAddr == 32'h21FF_FFFC && lastWdata == 32'h1234_5678, "R1 below window passes",
          lastAddr, 32'h21FF_FFFC);
    check(lockBreaks == 0, "R7 no lock breaks", 32'(lockBreaks), 32'd0);
    check(busyErrs == 0, "R9 ready low while busy", 32'(busyErrs), 32'd0);
    check(rspCountErrs == 0, "R9 one response each", 32'(rspCountErrs), 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_alias_byte();
    t_alias_half();
    t_alias_word();
    t_window1();
    t_bounds();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule